// File: doc/BRIEF.md
# Exponent Evaluation and Normalization Unit

This block measures how far a 36-bit fixed-point value sits from its normalized position and can then move it there. The word carries four guard bits above a sign bit at position 31. The unit counts how many leading bits, from bit 35 down, repeat the top bit. From that count it forms a signed shift amount: positive means shift left, negative means shift right into the guard bits, and zero means the value is already normalized.

The operand is either a full 36-bit accumulator value or a 16-bit word. A 16-bit word is placed in bits 31..16, sign-extended upward and zero-filled below. One start pulse evaluates the exponent into a shift-value register, which drives `exp_o`. The same pulse can also copy the exponent into an accumulator output. In normalize mode a second cycle passes the captured operand through a barrel shifter, steered by the shift-value register, and presents the normalized word.

Top module: `exp_norm_unit`

## Requirements
- R1: For a 36-bit operand, `exp_o` is a 6-bit two's-complement number equal to N-5. N is the count of leading bits, starting at bit 35, that equal bit 35. The reported value always lies in -4..+30.
- R2: An operand whose 36 bits are all zero or all one reports +30.
- R3: With `short_i`=1, `operand_i[15:0]` is placed in bits 31..16, bit 15 of it is copied into bits 35..32, bits 15..0 are zero, and `operand_i[35:16]` is ignored. The exponent is then never negative.
- R4: A start with `norm_i`=0 raises `done_o` for one cycle after the next clock edge, with `exp_o` updated and `result_o` unchanged.
- R5: A start with `norm_i`=1 keeps `done_o` low after the first edge and raises it for one cycle after the second edge, with `result_o` holding the shifted operand.
- R6: A positive exponent e gives `result_o` = operand shifted left by e with zeros filled from bit 0. A negative exponent gives an arithmetic right shift by its magnitude, with bit 35 replicated. For any exponent below +30 the result has bit 31 unequal to bit 30, and guard bits equal to bit 31.
- R7: A start with `copy_i`=1 loads `acc_o` with the new exponent sign-extended to 36 bits. Without it, `acc_o` keeps its value.
- R8: A start that arrives while a normalize is waiting for its shift cycle is ignored. It produces no extra `done_o` and no change to `exp_o`, `acc_o` or `result_o`.
- R9: After synchronous reset, `done_o` is low and `exp_o`, `acc_o` and `result_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation |
| norm_i | input | 1 | 1: evaluate and shift; 0: evaluate only |
| short_i | input | 1 | 1: operand is the 16-bit word in operand_i[15:0] |
| copy_i | input | 1 | Also copy the exponent to acc_o |
| operand_i | input | 36 | Value to evaluate |
| exp_o | output | 6 | Shift-value register (signed exponent) |
| acc_o | output | 36 | Accumulator copy of the exponent |
| result_o | output | 36 | Normalized value |
| done_o | output | 1 | One-cycle completion flag |

## Verification
The assertions take for granted that `start_i` is a plain level sampled on each clock edge. While a shift cycle is pending, start may be high; the design must drop it, and one property relies on that. The stimulus drives every input on the falling edge. It sends evaluate-only starts back to back and spaces normalize starts two cycles apart, except for one deliberate start placed in the shift cycle. The operands mix fixed corner values, every single-sign-run length and random words in both widths.

// File: rtl/exp_norm_pkg.sv
package exp_norm_pkg;

    parameter int WORD_W  = 36;   // full operand width
    parameter int GUARD_W = 4;    // guard bits above the sign position
    parameter int SHORT_W = 16;   // narrow operand width
    parameter int EXP_W   = 6;    // signed exponent width

    localparam int SIGN_POS  = WORD_W - GUARD_W - 1;          // 31
    localparam int CNT_W     = $clog2(WORD_W + 1);            // count of sign bits
    localparam int EXP_MAX   = WORD_W - GUARD_W - 2;          // +30
    localparam int LOW_FILL  = SIGN_POS + 1 - SHORT_W;        // zero bits below short word
    localparam int MAG_W     = EXP_W - 1;                     // shift magnitude bits

    typedef logic [WORD_W-1:0]       word_t;
    typedef logic signed [EXP_W-1:0] expv_t;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } norm_state_e;

    typedef struct packed {
        logic  do_norm;
        logic  do_copy;
        word_t value;
    } op_req_t;

    // Turn a sign-run count into the clamped exponent.
    function automatic expv_t exp_of_count(input logic [CNT_W-1:0] n);
        int e;
        e = int'(n) - (GUARD_W + 1);
        if (e > EXP_MAX) e = EXP_MAX;
        return expv_t'(e);
    endfunction

endpackage

// File: rtl/exp_operand_fmt.sv
module exp_operand_fmt
    import exp_norm_pkg::*;
(
    input  logic  short_i,
    input  word_t raw_i,
    output word_t word_o
);
    logic [SHORT_W-1:0] narrow;
    word_t              placed;

    assign narrow = raw_i[SHORT_W-1:0];
    assign placed = {{(WORD_W-SIGN_POS-1){narrow[SHORT_W-1]}}, narrow, {LOW_FILL{1'b0}}};

    always_comb begin
        word_o = short_i ? placed : raw_i;
    end

endmodule

// File: rtl/exp_lead_count.sv
module exp_lead_count
    import exp_norm_pkg::*;
(
    input  word_t word_i,
    output expv_t exp_o
);
    // diff[i] marks a change of value between bit i+1 and bit i
    logic [WORD_W-2:0] diff;
    logic [CNT_W-1:0]  run;

    genvar gi;
    generate
        for (gi = 0; gi < WORD_W-1; gi++) begin : g_diff
            assign diff[gi] = word_i[gi+1] ^ word_i[gi];
        end
    endgenerate

    always_comb begin
        run = CNT_W'(WORD_W);
        for (int i = 0; i < WORD_W-1; i++) begin
            if (diff[i]) run = CNT_W'(WORD_W - 1 - i);
        end
    end

    assign exp_o = exp_of_count(run);

endmodule

// File: rtl/exp_barrel_shift.sv
module exp_barrel_shift
    import exp_norm_pkg::*;
(
    input  word_t data_i,
    input  expv_t amt_i,
    output word_t data_o
);
    logic             go_right;
    logic [MAG_W-1:0] mag;
    word_t            stage [MAG_W+1];

    assign go_right = amt_i[EXP_W-1];
    assign mag      = go_right ? MAG_W'(-amt_i) : MAG_W'(amt_i);
    assign stage[0] = data_i;

    genvar gs;
    generate
        for (gs = 0; gs < MAG_W; gs++) begin : g_stage
            localparam int STEP = 1 << gs;
            word_t lsh, rsh;
            assign lsh = {stage[gs][WORD_W-1-STEP:0], {STEP{1'b0}}};
            assign rsh = {{STEP{stage[gs][WORD_W-1]}}, stage[gs][WORD_W-1:STEP]};
            assign stage[gs+1] = !mag[gs] ? stage[gs] : (go_right ? rsh : lsh);
        end
    endgenerate

    assign data_o = stage[MAG_W];

endmodule

// File: rtl/exp_norm_unit.sv
module exp_norm_unit
    import exp_norm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              norm_i,
    input  logic              short_i,
    input  logic              copy_i,
    input  logic [WORD_W-1:0] operand_i,
    output logic [EXP_W-1:0]  exp_o,
    output logic [WORD_W-1:0] acc_o,
    output logic [WORD_W-1:0] result_o,
    output logic              done_o
);
    norm_state_e state_q;
    word_t       op_q, acc_q, res_q;
    expv_t       sv_q;
    logic        done_q;
    op_req_t     req;
    expv_t       exp_c;
    word_t       shifted_c;
    logic        accept;

    exp_operand_fmt u_fmt (
        .short_i (short_i),
        .raw_i   (operand_i),
        .word_o  (req.value)
    );
    assign req.do_norm = norm_i;
    assign req.do_copy = copy_i;

    exp_lead_count u_cnt (
        .word_i (req.value),
        .exp_o  (exp_c)
    );

    exp_barrel_shift u_shf (
        .data_i (op_q),
        .amt_i  (sv_q),
        .data_o (shifted_c)
    );

    assign accept = start_i && (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
            sv_q    <= '0;
            acc_q   <= '0;
            res_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state_q == ST_SHIFT) begin
                res_q   <= shifted_c;
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
            end else if (accept) begin
                op_q <= req.value;
                sv_q <= exp_c;
                if (req.do_copy)
                    acc_q <= {{(WORD_W-EXP_W){exp_c[EXP_W-1]}}, exp_c};
                if (req.do_norm) state_q <= ST_SHIFT;
                else             done_q  <= 1'b1;
            end
        end
    end

    assign exp_o    = sv_q;
    assign acc_o    = acc_q;
    assign result_o = res_q;
    assign done_o   = done_q;

    AST_EXP_RANGE: assert property (@(posedge clk) disable iff (rst)
        ($signed(exp_o) >= -GUARD_W) && ($signed(exp_o) <= EXP_MAX)); // R1

    AST_SHORT_NONNEG: assert property (@(posedge clk) disable iff (rst)
        (accept && short_i) |=> !exp_o[EXP_W-1]); // R3

    AST_EVAL_DONE: assert property (@(posedge clk) disable iff (rst)
        (accept && !norm_i) |=> done_o); // R4

    AST_NORM_WAIT: assert property (@(posedge clk) disable iff (rst)
        (accept && norm_i) |=> (!done_o && state_q == ST_SHIFT)); // R5

    AST_SHIFT_DONE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SHIFT) |=> (done_o && state_q == ST_IDLE)); // R5

    AST_NORMALIZED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SHIFT && $signed(sv_q) != EXP_MAX) |=>
        (result_o[SIGN_POS] != result_o[SIGN_POS-1] &&
         result_o[WORD_W-1:SIGN_POS] == {(GUARD_W+1){result_o[SIGN_POS]}})); // R6

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(accept && copy_i) |=> $stable(acc_o)); // R7

    AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SHIFT) |=> ($stable(exp_o) && $stable(acc_o))); // R8

endmodule

// File: tb/tb_exp_norm_unit.sv
module tb_exp_norm_unit;
    localparam int W = 36;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0, norm_i = 1'b0, short_i = 1'b0, copy_i = 1'b0;
    logic [W-1:0]  operand_i = '0;
    logic [5:0]    exp_o;
    logic [W-1:0]  acc_o, result_o;
    logic          done_o;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [5:0]   e;
        logic [W-1:0] res;
        logic [W-1:0] acc;
        string        tag;
    } item_t;

    item_t        sb[$];
    logic [W-1:0] m_res = '0;
    logic [W-1:0] m_acc = '0;

    exp_norm_unit dut (
        .clk(clk), .rst(rst), .start_i(start_i), .norm_i(norm_i),
        .short_i(short_i), .copy_i(copy_i), .operand_i(operand_i),
        .exp_o(exp_o), .acc_o(acc_o), .result_o(result_o), .done_o(done_o)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] place(input logic sh, input logic [W-1:0] v);
        logic [W-1:0] r;
        if (!sh) return v;
        r = '0;
        r[31:16] = v[15:0];
        for (int k = 32; k < W; k++) r[k] = v[15];
        return r;
    endfunction

    function automatic int ref_exp(input logic [W-1:0] v);
        int n = 0;
        for (int k = W-1; k >= 0; k--) begin
            if (v[k] != v[W-1]) break;
            n++;
        end
        return (n - 5 > 30) ? 30 : n - 5;
    endfunction

    function automatic logic [W-1:0] ref_shift(input logic [W-1:0] v, input int e);
        if (e >= 0) return v << e;
        return W'($signed(v) >>> (-e));
    endfunction

    // driver: one start, expected item pushed into the scoreboard
    task automatic issue(input logic [W-1:0] v, input logic sh, input logic nm, input logic cp, input string tag);
        item_t it;
        logic [W-1:0] pv;
        int e;
        pv = place(sh, v);
        e  = ref_exp(pv);
        if (cp) m_acc = W'(e);
        if (nm) m_res = ref_shift(pv, e);
        it.e = 6'(e); it.res = m_res; it.acc = m_acc; it.tag = tag;
        sb.push_back(it);
        operand_i = v; short_i = sh; norm_i = nm; copy_i = cp; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (nm) @(negedge clk);
    endtask

    // monitor: pops on each done
    always @(negedge clk) begin
        if (!rst && done_o) begin
            if (sb.size() == 0) begin
                check(1'b0, "R8 unexpected done", W'(done_o), '0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(exp_o == it.e, {it.tag, " R1 exp"}, W'(exp_o), W'(it.e));
                check(result_o == it.res, {it.tag, " R6 result"}, result_o, it.res);
                check(acc_o == it.acc, {it.tag, " R7 acc"}, acc_o, it.acc);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R4 actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check(done_o == 1'b0, "R9 done", W'(done_o), '0);
        check(exp_o == '0, "R9 exp", W'(exp_o), '0);
        check(acc_o == '0, "R9 acc", acc_o, '0);
        check(result_o == '0, "R9 result", result_o, '0);
        rst = 1'b0;
        @(negedge clk);

        // R1 R6 table cases, normalize with copy
        issue(36'h00A000000, 0, 1, 1, "R1 n8");
        issue(36'hCA0000000, 0, 1, 1, "R1 n2");
        issue(36'h070000000, 0, 1, 1, "R1 n5");
        issue(36'h800000000, 0, 1, 0, "R6 min");
        // R2 all same
        issue(36'h000000000, 0, 1, 1, "R2 zeros");
        issue(36'hFFFFFFFFF, 0, 1, 1, "R2 ones");
        issue(36'h000000001, 0, 1, 1, "R6 one");
        // R3 short words; high bits must be ignored
        issue(36'hABCDE0001, 1, 1, 1, "R3 pos");
        issue(36'h123458000, 1, 1, 1, "R3 neg");
        issue(36'h00000FFFF, 1, 1, 0, "R3 m1");
        // R4 evaluate-only, back to back, result held
        issue(36'h7FFFFFFFF, 0, 0, 1, "R4 a");
        issue(36'h000F00000, 0, 0, 0, "R4 b");
        issue(36'h3C0000000, 0, 0, 1, "R4 c");
        @(negedge clk);
        // R5 timing: done low one cycle after normalize start
        issue(36'h00000F000, 0, 1, 1, "R5 t");
        // every sign-run length
        for (int k = 0; k < W; k++) begin
            issue(36'h1 << k, 0, 1, 1, "R1 pos run");
            issue(~(36'h1 << k), 0, 1, 0, "R1 neg run");
        end
        // R8 start in shift cycle ignored
        begin
            item_t it;
            logic [W-1:0] pv;
            int e;
            pv = 36'h004000000;
            e = ref_exp(pv);
            m_acc = W'(e);
            m_res = ref_shift(pv, e);
            it.e = 6'(e); it.res = m_res; it.acc = m_acc; it.tag = "R8 first";
            sb.push_back(it);
            operand_i = pv; short_i = 0; norm_i = 1; copy_i = 1; start_i = 1;
            @(negedge clk);
            check(done_o == 1'b0, "R5 no early done", W'(done_o), '0);
            operand_i = 36'hF00000000; start_i = 1;   // lands in shift cycle
            @(negedge clk);
            start_i = 0;
            repeat (3) @(negedge clk);
            check(exp_o == 6'(e), "R8 exp kept", W'(exp_o), W'(e));
            check(acc_o == m_acc, "R8 acc kept", acc_o, m_acc);
            check(result_o == m_res, "R8 result kept", result_o, m_res);
        end
        // random mix
        for (int k = 0; k < 300; k++) begin
            logic [W-1:0] v;
            v = {$urandom, $urandom} >> ($urandom % 40);
            if ($urandom % 2) v = ~v;
            issue(v, 1'($urandom), 1'($urandom), 1'($urandom), "R6 rand");
        end
        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R4 all done", W'(sb.size()), '0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule